// File: doc/BRIEF.md
# Configuration Access Request Translator

This block sits between a simple CPU-side register port and the request side of a PCIe root port. Software first programs a header register with the target bus number, device/function number, a byte-enable mask and a force flag. It then reads or writes a 4 KB configuration window. Each window access becomes one configuration request descriptor. The descriptor carries the bus, the devfn, the dword-aligned register address, the byte enables, the direction and the full 32-bit write data.

A completer, modelled by the testbench, answers each request with a completion. The completion holds read data and an unsupported-request flag. The block then returns the data, or a plain acknowledgement for a write, to the CPU side. Only one request may be in flight at a time. The CPU port reports not-ready until the outstanding request completes.

Byte enables come from one of two sources. When the force flag is set, the programmed mask replaces the lanes of each access. Software then issues full-word accesses, with sub-word write data already moved into its lane position. When the flag is clear, the access's own byte strobes are used.

Top module: `cfg_xlat_top`

## Requirements
- R1: After reset, `rq_valid` and `cpu_ack` are 0, `cpu_ready` is 1, and the header register reads back as 0.
- R2: A write to CPU address 0x140 loads the header register from the write data. The fields are devfn in bits 7:0, bus in bits 15:8, the byte-enable mask in bits 19:16 and the force flag in bit 20. A read of 0x140 returns those 21 bits, with bits 31:21 as 0. Both accesses are answered with `cpu_ack` high for one cycle, in the cycle after acceptance.
- R3: An access accepted at an address from 0x1000 to 0x1FFF raises `rq_valid` in the cycle after acceptance. The request carries bus and devfn from the header, `rq_reg` equal to the window offset (address bits 11:0) with bits 1:0 cleared, `rq_write` equal to the access direction, and `rq_data` equal to the full 32-bit write data.
- R4: With the force flag set, `rq_be` equals the programmed mask, whatever the access's strobes are. For a sub-word access of 1, 2 or 4 bytes at low offset bits `o`, the correct mask is ((1<<size)-1)<<o truncated to 4 bits.
- R5: With the force flag clear, `rq_be` equals the `cpu_wstrb` value of the accepted access. This holds for reads and writes alike.
- R6: While a request is outstanding, `cpu_ready` is 0, every request field stays stable, and any CPU access presented is not accepted. In particular, a stalled header write leaves the header unchanged.
- R7: At the first clock edge where `cpl_valid` is high while `rq_valid` is high, `rq_valid` falls and `cpu_ack` pulses for one cycle. `cpu_rdata` then holds `cpl_data` for a read, or 0 for a write. `cpu_ready` returns to 1 in the same cycle.
- R8: A read whose completion has `cpl_ur` set returns 0xFFFFFFFF on `cpu_rdata`.
- R9: An access to any other address raises no request and is acknowledged in the cycle after acceptance. A read returns 0, and a write changes nothing, including the header register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_wstrb | input | 4 | CPU byte strobes |
| cpu_ready | output | 1 | No request outstanding; an access can be accepted |
| cpu_ack | output | 1 | One-cycle response pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| rq_valid | output | 1 | Configuration request outstanding |
| rq_write | output | 1 | Request is a configuration write |
| rq_bus | output | 8 | Target bus number |
| rq_devfn | output | 8 | Target device/function number |
| rq_reg | output | 12 | Dword-aligned configuration register address |
| rq_be | output | 4 | Request byte enables |
| rq_data | output | 32 | Request write data |
| cpl_valid | input | 1 | Completion for the outstanding request |
| cpl_ur | input | 1 | Completion status: unsupported request |
| cpl_data | input | 32 | Completion read data |

## Verification
The main sweep covers every byte-enable pattern that the three access sizes and four lane offsets can produce. It runs in both force settings and for both directions. In force mode the strobes are all ones, and in strobe mode the header mask is the inverse of the expected one. A wrong source for `rq_be` therefore cannot pass. Each run uses a fresh bus and devfn, an offset with varied upper bits, and a completion delay of zero to three cycles; these separate field mix-ups, alignment faults and early completions. A stalled header write during every outstanding request, together with unsupported-request completions and accesses outside both the window and the header, checks the stall, error-data and ignore paths.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int BE_W    = 4;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 12;

  // Header layout: devfn at bit 0, bus above it, mask above that, force on top
  typedef struct packed {
    logic               fbe;
    logic [BE_W-1:0]    be;
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
  } cfg_hdr_t;

  localparam int HDR_W = $bits(cfg_hdr_t);

  typedef struct packed {
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [REG_W-1:0]   regno;
    logic [BE_W-1:0]    be;
    logic               wr;
    logic [DATA_W-1:0]  data;
  } cfg_req_t;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int ADDR_W = 13,
  parameter int REG_W  = 12,
  parameter logic [ADDR_W-1:0] HDR_OFF  = 13'h0140,
  parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_hdr,
  output logic              hit_win,
  output logic [REG_W-1:0]  win_off
);
  assign hit_hdr = (addr == HDR_OFF);
  assign hit_win = (addr[ADDR_W-1:REG_W] == WIN_BASE[ADDR_W-1:REG_W]);
  assign win_off = addr[REG_W-1:0];
endmodule

// File: rtl/cfg_hdr_reg.sv
module cfg_hdr_reg
  import cfg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output cfg_hdr_t          hdr,
  output logic [DATA_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (rst)        hdr <= '0;
    else if (wr_en) hdr <= cfg_hdr_t'(wdata[HDR_W-1:0]);
  end

  assign rd_word = {{(DATA_W-HDR_W){1'b0}}, hdr};
endmodule

// File: rtl/cfg_req_eng.sv
module cfg_req_eng
  import cfg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  cfg_req_t          req_in,
  input  logic              cpl_valid,
  input  logic              cpl_ur,
  input  logic [DATA_W-1:0] cpl_data,
  output logic              busy,
  output cfg_req_t          req_q,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic closing;
  assign closing = busy && cpl_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      req_q <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= closing;
      if (start) begin
        busy  <= 1'b1;
        req_q <= req_in;
      end else if (closing) begin
        busy <= 1'b0;
        if (req_q.wr)    rdata <= '0;
        else if (cpl_ur) rdata <= '1;
        else             rdata <= cpl_data;
      end
    end
  end
endmodule

// File: rtl/cfg_xlat_top.sv
module cfg_xlat_top
  import cfg_xlat_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] HDR_OFF  = 13'h0140,
  parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [BE_W-1:0]    cpu_wstrb,
  output logic               cpu_ready,
  output logic               cpu_ack,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               rq_valid,
  output logic               rq_write,
  output logic [BUS_W-1:0]   rq_bus,
  output logic [DEVFN_W-1:0] rq_devfn,
  output logic [REG_W-1:0]   rq_reg,
  output logic [BE_W-1:0]    rq_be,
  output logic [DATA_W-1:0]  rq_data,
  input  logic               cpl_valid,
  input  logic               cpl_ur,
  input  logic [DATA_W-1:0]  cpl_data
);
  localparam int LANE_SKIP = 2;   // byte-offset bits below a dword

  logic              hit_hdr, hit_win;
  logic [REG_W-1:0]  win_off;
  cfg_hdr_t          hdr;
  logic [DATA_W-1:0] hdr_word;
  logic              busy, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  cfg_req_t          new_req, cur_req;
  logic [BE_W-1:0]   sel_be;
  logic              accept;
  logic              loc_ack;
  logic [DATA_W-1:0] loc_rdata;

  assign cpu_ready = !busy;
  assign accept    = cpu_req && cpu_ready;

  cfg_addr_dec #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .HDR_OFF(HDR_OFF), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(cpu_addr), .hit_hdr(hit_hdr), .hit_win(hit_win), .win_off(win_off)
  );

  cfg_hdr_reg u_hdr (
    .clk(clk), .rst(rst),
    .wr_en(accept && hit_hdr && cpu_we),
    .wdata(cpu_wdata),
    .hdr(hdr), .rd_word(hdr_word)
  );

  // Per-lane byte-enable source: programmed mask or access strobe
  for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
    assign sel_be[ln] = hdr.fbe ? hdr.be[ln] : cpu_wstrb[ln];
  end

  always_comb begin
    new_req       = '0;
    new_req.bus   = hdr.bus;
    new_req.devfn = hdr.devfn;
    new_req.regno = {win_off[REG_W-1:LANE_SKIP], {LANE_SKIP{1'b0}}};
    new_req.be    = sel_be;
    new_req.wr    = cpu_we;
    new_req.data  = cpu_wdata;
  end

  cfg_req_eng u_eng (
    .clk(clk), .rst(rst),
    .start(accept && hit_win),
    .req_in(new_req),
    .cpl_valid(cpl_valid), .cpl_ur(cpl_ur), .cpl_data(cpl_data),
    .busy(busy), .req_q(cur_req), .done(eng_done), .rdata(eng_rdata)
  );

  // Header and unmapped accesses finish locally in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_ack   <= 1'b0;
      loc_rdata <= '0;
    end else begin
      loc_ack <= accept && !hit_win;
      if (accept && !hit_win)
        loc_rdata <= (hit_hdr && !cpu_we) ? hdr_word : '0;
    end
  end

  assign cpu_ack   = loc_ack | eng_done;
  assign cpu_rdata = eng_done ? eng_rdata : loc_rdata;

  assign rq_valid = busy;
  assign rq_write = cur_req.wr;
  assign rq_bus   = cur_req.bus;
  assign rq_devfn = cur_req.devfn;
  assign rq_reg   = cur_req.regno;
  assign rq_be    = cur_req.be;
  assign rq_data  = cur_req.data;
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk
  import cfg_xlat_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_req,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_ready,
  input logic               cpu_ack,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               rq_valid,
  input logic               rq_write,
  input logic [BUS_W-1:0]   rq_bus,
  input logic [DEVFN_W-1:0] rq_devfn,
  input logic [REG_W-1:0]   rq_reg,
  input logic [BE_W-1:0]    rq_be,
  input logic [DATA_W-1:0]  rq_data,
  input logic               cpl_valid,
  input logic               cpl_ur
);
  logic in_win;
  assign in_win = (cpu_addr[ADDR_W-1:REG_W] == WIN_BASE[ADDR_W-1:REG_W]);

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> !cpu_ready);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !cpl_valid |=> rq_valid && $stable(rq_bus) && $stable(rq_devfn)
      && $stable(rq_reg) && $stable(rq_be) && $stable(rq_write) && $stable(rq_data));

  // R3
  reg_align_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> rq_reg[1:0] == 2'b00);

  // R3
  win_start_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready && in_win |=> rq_valid && !cpu_ack);

  // R9
  local_ack_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ready && !in_win |=> cpu_ack && !rq_valid);

  // R7
  cpl_close_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid && cpl_valid |=> !rq_valid && cpu_ack && cpu_ready);

  // R8
  ur_ones_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid && cpl_valid && cpl_ur && !rq_write |=> cpu_rdata == '1);
endmodule

bind cfg_xlat_top cfg_xlat_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
  .rq_valid(rq_valid), .rq_write(rq_write), .rq_bus(rq_bus),
  .rq_devfn(rq_devfn), .rq_reg(rq_reg), .rq_be(rq_be), .rq_data(rq_data),
  .cpl_valid(cpl_valid), .cpl_ur(cpl_ur)
);

// File: tb/cfg_xlat_top_tb.sv
module cfg_xlat_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_wstrb = '0;
  logic        cpu_ready, cpu_ack;
  logic [31:0] cpu_rdata;
  logic        rq_valid, rq_write;
  logic [7:0]  rq_bus, rq_devfn;
  logic [11:0] rq_reg;
  logic [3:0]  rq_be;
  logic [31:0] rq_data;
  logic        cpl_valid = 1'b0, cpl_ur = 1'b0;
  logic [31:0] cpl_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  cfg_xlat_top u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb),
    .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .rq_valid(rq_valid), .rq_write(rq_write), .rq_bus(rq_bus),
    .rq_devfn(rq_devfn), .rq_reg(rq_reg), .rq_be(rq_be), .rq_data(rq_data),
    .cpl_valid(cpl_valid), .cpl_ur(cpl_ur), .cpl_data(cpl_data)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Header or unmapped access; returns read data seen with the ack
  task automatic loc_acc(input logic we, input logic [12:0] addr, input logic [31:0] wd,
                         input string tag, output logic [31:0] rd);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_wstrb = 4'hF;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    chk(cpu_ack == 1'b1, {tag, " ack"}, 32'(cpu_ack), 32'd1);
    chk(rq_valid == 1'b0, {tag, " no request"}, 32'(rq_valid), 32'd0);
    rd = cpu_rdata;
    @(negedge clk);
    chk(cpu_ack == 1'b0, {tag, " ack single"}, 32'(cpu_ack), 32'd0);
  endtask

  task automatic hdr_read_chk(input logic [31:0] exp, input string tag);
    logic [31:0] rd;
    loc_acc(1'b0, 13'h0140, 32'h0, tag, rd);
    chk(rd == exp, {tag, " header readback"}, rd, exp);
  endtask

  // Window access with completer model; stalled header write during wait
  task automatic win_acc(input logic we, input logic [11:0] off, input logic [31:0] wd,
                         input logic [3:0] st, input int dly, input logic ur,
                         input logic [31:0] cd, input logic [7:0] e_bus,
                         input logic [7:0] e_devfn, input logic [3:0] e_be,
                         input string be_tag);
    logic [31:0] e_rd;
    logic [11:0] e_reg;
    e_reg = {off[11:2], 2'b00};
    e_rd  = we ? 32'h0 : (ur ? 32'hFFFF_FFFF : cd);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {1'b1, off}; cpu_wdata = wd; cpu_wstrb = st;
    @(posedge clk);
    @(negedge clk);
    // present a header write that must stall
    cpu_we = 1'b1; cpu_addr = 13'h0140; cpu_wdata = 32'h001F_FFFF;
    chk(rq_valid == 1'b1, "R3 rq_valid", 32'(rq_valid), 32'd1);
    chk(rq_bus == e_bus, "R3 bus", 32'(rq_bus), 32'(e_bus));
    chk(rq_devfn == e_devfn, "R3 devfn", 32'(rq_devfn), 32'(e_devfn));
    chk(rq_reg == e_reg, "R3 reg", 32'(rq_reg), 32'(e_reg));
    chk(rq_write == we, "R3 dir", 32'(rq_write), 32'(we));
    chk(rq_data == wd, "R3 data", rq_data, wd);
    chk(rq_be == e_be, be_tag, 32'(rq_be), 32'(e_be));
    chk(cpu_ready == 1'b0, "R6 ready low", 32'(cpu_ready), 32'd0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(rq_valid && !cpu_ready && !cpu_ack, "R6 held", {rq_valid, cpu_ready, cpu_ack}, 32'b100);
      chk(rq_reg == e_reg && rq_be == e_be, "R6 stable", {rq_reg, rq_be}, {e_reg, e_be});
    end
    cpu_req = 1'b0;
    cpl_valid = 1'b1; cpl_ur = ur; cpl_data = cd;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_ur = 1'b0;
    chk(cpu_ack == 1'b1 && rq_valid == 1'b0, "R7 close", {cpu_ack, rq_valid}, 32'b10);
    chk(cpu_ready == 1'b1, "R7 ready back", 32'(cpu_ready), 32'd1);
    chk(cpu_rdata == e_rd, ur ? "R8 ur data" : "R7 data", cpu_rdata, e_rd);
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R7 ack single", 32'(cpu_ack), 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd, hw;
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!rq_valid && !cpu_ack && cpu_ready, "R1 reset outputs", {rq_valid, cpu_ack, cpu_ready}, 32'b001);
    hdr_read_chk(32'h0, "R1");

    // R2: field storage and upper bits
    loc_acc(1'b1, 13'h0140, 32'hFFFF_FFFF, "R2 write", rd);
    hdr_read_chk(32'h001F_FFFF, "R2 upper bits");
    loc_acc(1'b1, 13'h0140, 32'h0013_A5C3, "R2 write", rd);
    hdr_read_chk(32'h0013_A5C3, "R2 fields");

    // Sweep: force, size, lane offset, direction
    k = 0;
    for (int f = 0; f < 2; f++)
      for (int si = 0; si < 3; si++)
        for (int lo = 0; lo < 4; lo++)
          for (int we = 0; we < 2; we++) begin
            int          sz;
            logic [3:0]  mask, hbe, st;
            logic [7:0]  b, d;
            logic [11:0] off;
            logic [31:0] wd;
            sz   = 1 << si;
            mask = 4'(((1 << sz) - 1) << lo);
            hbe  = f ? mask : ~mask;
            st   = f ? 4'hF : mask;
            b    = 8'h40 ^ 8'(k);
            d    = 8'(k * 7);
            off  = {10'(k * 37), 2'(lo)};
            wd   = (sz == 4) ? (32'hDEAD_0000 | 32'(k)) : ((32'hA5 + 32'(k)) << (8 * lo));
            hw   = {11'h0, 1'(f), hbe, b, d};
            loc_acc(1'b1, 13'h0140, hw, "R2 program", rd);
            win_acc(1'(we), off, wd, st, k % 4, 1'b0, 32'h1234_0000 | 32'(k),
                    b, d, mask, f ? "R4 forced be" : "R5 strobe be");
            if (k % 8 == 0) hdr_read_chk(hw, "R6 stalled write ignored");
            k++;
          end

    // Window edges and unsupported request
    loc_acc(1'b1, 13'h0140, 32'h001F_0201, "R2 program", rd);
    win_acc(1'b0, 12'hFFF, 32'h0, 4'h1, 2, 1'b1, 32'h5555_5555, 8'h02, 8'h01, 4'hF, "R4 forced be");
    win_acc(1'b0, 12'h000, 32'h0, 4'h1, 0, 1'b0, 32'h0BAD_F00D, 8'h02, 8'h01, 4'hF, "R4 forced be");
    win_acc(1'b1, 12'h7FE, 32'h1111_0000, 4'hC, 1, 1'b1, 32'h0, 8'h02, 8'h01, 4'hF, "R4 forced be");

    // R9: other addresses
    loc_acc(1'b1, 13'h0144, 32'h0000_0000, "R9 write other", rd);
    loc_acc(1'b1, 13'h0FFC, 32'h0000_0000, "R9 write other", rd);
    hdr_read_chk(32'h001F_0201, "R9 header untouched");
    loc_acc(1'b0, 13'h0000, 32'h0, "R9 read other", rd);
    chk(rd == 32'h0, "R9 read zero", rd, 32'h0);
    loc_acc(1'b0, 13'h0FFF, 32'h0, "R9 read other", rd);
    chk(rd == 32'h0, "R9 read zero", rd, 32'h0);

    finish_run();
  end
endmodule